// File: doc/BRIEF.md
# Secure-Aware Interrupt Controller

This block gathers 128 level-sensitive interrupt lines and turns them into two processor requests: a normal interrupt request for sources marked non-secure and a fast interrupt request for sources marked secure. Software sets each source up through a single-cycle 32-bit register port.

Each source has an enable bit and an 8-bit priority. A global threshold decides which priorities are urgent enough to be forwarded, and a control register gates each output. Enable bits can only be changed through separate write-one-to-set and write-one-to-clear addresses. A pending view per bank of 32 shows which sources are asserted and enabled.

The two request outputs are registered. They follow any change in the lines or in the configuration one clock later. Register reads are combinational from the address.

Top module: `secure_irq_ctrl`

## Requirements
- R1: After reset every enable, security, priority, mask and control bit is 0. Every register reads 0, and both outputs stay low even with all lines asserted.
- R2: A write to enable-set word b (address 0x100 + 4*b) enables source 32*b + i for each bit i written as 1. Bits written as 0 leave their enables unchanged. Reading either the set word or the clear word of bank b returns the current enables.
- R3: A write to enable-clear word b (address 0x180 + 4*b) disables source 32*b + i for each bit i written as 1. Bits written as 0 leave their enables unchanged.
- R4: Pending word b (address 0xD00 + 4*b, read-only) returns bit i = line(32*b+i) AND enable(32*b+i). It follows the line level with no latching.
- R5: The priority of source n is held in bits [8*(n mod 4)+7 : 8*(n mod 4)] of the priority word at address 0x400 + 4*(n/4), and it reads back there.
- R6: A pending source is forwarded only when its priority is strictly less than the mask in bits [7:0] of address 0x00C. A priority equal to or above the mask is not forwarded, and priority 0 is the most urgent.
- R7: Security bit i of word b (address 0x080 + 4*b) set to 1 routes source 32*b+i to irq_o. Set to 0, it routes the source to fiq_o.
- R8: Control at address 0x000 has bit 0 as global enable and bit 1 as non-secure enable. irq_o can be high only when both bits are 1. fiq_o can be high only when bit 0 is 1.
- R9: irq_o and fiq_o are registered. They change at the first rising clock edge after a change in the lines or in the configuration, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 128 | Level-sensitive interrupt lines, bit n is source n |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Normal interrupt request (non-secure sources) |
| fiq_o | output | 1 | Fast interrupt request (secure sources) |

## Verification
The bench builds the block with its default parameters: 128 sources, 32-bit words and 8-bit priorities. This brings the last bank and the last priority word into reach, along with the highest byte lane of a packed priority word. With these values, the byte-lane mapping is checked by behaviour: only one source in a word is asserted, and only its own byte decides whether it is forwarded. Mask equality, the two-bit output gating and the one-cycle output delay are each driven to their boundary.

// File: rtl/sic_pkg.sv
package sic_pkg;
   // Register window offsets (byte addresses)
   localparam int unsigned OFS_CTRL  = 'h000;
   localparam int unsigned OFS_PMASK = 'h00C;
   localparam int unsigned OFS_SEC   = 'h080;
   localparam int unsigned OFS_ENSET = 'h100;
   localparam int unsigned OFS_ENCLR = 'h180;
   localparam int unsigned OFS_PRIO  = 'h400;
   localparam int unsigned OFS_PEND  = 'hD00;
   // Control bit positions
   localparam int unsigned CTRL_GLOBAL_BIT = 0;
   localparam int unsigned CTRL_NONSEC_BIT = 1;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
   import sic_pkg::*;
#(
   parameter int NUM_SRC = 128,
   parameter int DATA_W  = 32,
   parameter int PRIO_W  = 8,
   parameter int ADDR_W  = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [NUM_SRC-1:0]        pend,
   output logic [DATA_W-1:0]         rdata,
   output logic [NUM_SRC-1:0]        en_q,
   output logic [NUM_SRC-1:0]        sec_q,
   output logic [NUM_SRC*PRIO_W-1:0] prio_q,
   output logic [PRIO_W-1:0]         mask_q,
   output logic                      ge_q,
   output logic                      nse_q
);
   localparam int NUM_BANK  = NUM_SRC / DATA_W;
   localparam int PER_WORD  = DATA_W / PRIO_W;
   localparam int NUM_PWORD = NUM_SRC / PER_WORD;

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_PMASK = ADDR_W'(OFS_PMASK);

   // Control and mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ge_q   <= 1'b0;
         nse_q  <= 1'b0;
         mask_q <= '0;
      end else if (we) begin
         if (addr == A_CTRL) begin
            ge_q  <= wdata[CTRL_GLOBAL_BIT];
            nse_q <= wdata[CTRL_NONSEC_BIT];
         end
         if (addr == A_PMASK) mask_q <= wdata[PRIO_W-1:0];
      end
   end

   // Per-bank enable and security words
   for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_ENSET + 4*b);
      localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_ENCLR + 4*b);
      localparam logic [ADDR_W-1:0] A_SEC = ADDR_W'(OFS_SEC + 4*b);
      logic [DATA_W-1:0] set_m, clr_m;
      assign set_m = (we && addr == A_SET) ? wdata : '0;
      assign clr_m = (we && addr == A_CLR) ? wdata : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[b*DATA_W +: DATA_W]  <= '0;
            sec_q[b*DATA_W +: DATA_W] <= '0;
         end else begin
            en_q[b*DATA_W +: DATA_W] <= (en_q[b*DATA_W +: DATA_W] | set_m) & ~clr_m;
            if (we && addr == A_SEC) sec_q[b*DATA_W +: DATA_W] <= wdata;
         end
      end
   end

   // Packed priority words
   for (genvar w = 0; w < NUM_PWORD; w++) begin : g_pword
      localparam logic [ADDR_W-1:0] A_PW = ADDR_W'(OFS_PRIO + 4*w);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 prio_q[w*DATA_W +: DATA_W] <= '0;
         else if (we && addr == A_PW) prio_q[w*DATA_W +: DATA_W] <= wdata;
      end
   end

   // Read multiplexer
   always_comb begin
      rdata = '0;
      if (addr == A_CTRL) begin
         rdata[CTRL_GLOBAL_BIT] = ge_q;
         rdata[CTRL_NONSEC_BIT] = nse_q;
      end
      if (addr == A_PMASK) rdata[PRIO_W-1:0] = mask_q;
      for (int b = 0; b < NUM_BANK; b++) begin
         if (addr == ADDR_W'(OFS_ENSET + 4*b) || addr == ADDR_W'(OFS_ENCLR + 4*b))
            rdata = en_q[b*DATA_W +: DATA_W];
         if (addr == ADDR_W'(OFS_SEC + 4*b))  rdata = sec_q[b*DATA_W +: DATA_W];
         if (addr == ADDR_W'(OFS_PEND + 4*b)) rdata = pend[b*DATA_W +: DATA_W];
      end
      for (int w = 0; w < NUM_PWORD; w++) begin
         if (addr == ADDR_W'(OFS_PRIO + 4*w)) rdata = prio_q[w*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/sic_qualify.sv
module sic_qualify #(
   parameter int NUM_SRC = 128,
   parameter int PRIO_W  = 8
) (
   input  logic [NUM_SRC-1:0]        src,
   input  logic [NUM_SRC-1:0]        en,
   input  logic [NUM_SRC-1:0]        sec,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]         mask,
   output logic [NUM_SRC-1:0]        pend,
   output logic                      want_irq,
   output logic                      want_fiq
);
   logic [NUM_SRC-1:0] elig;

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      assign pend[n] = src[n] & en[n];
      assign elig[n] = pend[n] & (prio[n*PRIO_W +: PRIO_W] < mask);
   end

   assign want_irq = |(elig & sec);
   assign want_fiq = |(elig & ~sec);
endmodule

// File: rtl/sic_outreg.sv
module sic_outreg (
   input  logic clk,
   input  logic rst_n,
   input  logic want_irq,
   input  logic want_fiq,
   input  logic ge,
   input  logic nse,
   output logic irq_o,
   output logic fiq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         fiq_o <= 1'b0;
      end else begin
         irq_o <= want_irq & ge & nse;
         fiq_o <= want_fiq & ge;
      end
   end
endmodule

// File: rtl/secure_irq_ctrl.sv
module secure_irq_ctrl #(
   parameter int NUM_SRC = 128,
   parameter int DATA_W  = 32,
   parameter int PRIO_W  = 8,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_o,
   output logic               fiq_o
);
   localparam int NUM_BANK  = NUM_SRC / DATA_W;
   localparam int NUM_PWORD = NUM_SRC * PRIO_W / DATA_W;

   // Elaboration-time parameter checks
   if (NUM_SRC % DATA_W != 0) begin : g_bad_banks
      $error("NUM_SRC must be a multiple of DATA_W");
   end
   if (DATA_W % PRIO_W != 0) begin : g_bad_prio
      $error("PRIO_W must divide DATA_W");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end
   if (NUM_BANK * 4 > 'h80) begin : g_bad_bank_window
      $error("too many banks for the register windows");
   end
   if (NUM_PWORD * 4 > 'h900) begin : g_bad_prio_window
      $error("too many priority words for the priority window");
   end

   logic [NUM_SRC-1:0]        en_q, sec_q, pend;
   logic [NUM_SRC*PRIO_W-1:0] prio_q;
   logic [PRIO_W-1:0]         mask_q;
   logic                      ctrl_ge, ctrl_nse, want_irq, want_fiq;

   sic_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .pend(pend), .rdata(reg_rdata), .en_q(en_q), .sec_q(sec_q), .prio_q(prio_q),
      .mask_q(mask_q), .ge_q(ctrl_ge), .nse_q(ctrl_nse)
   );

   sic_qualify #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_qual (
      .src(src_i), .en(en_q), .sec(sec_q), .prio(prio_q), .mask(mask_q),
      .pend(pend), .want_irq(want_irq), .want_fiq(want_fiq)
   );

   sic_outreg u_out (
      .clk(clk), .rst_n(rst_n), .want_irq(want_irq), .want_fiq(want_fiq),
      .ge(ctrl_ge), .nse(ctrl_nse), .irq_o(irq_o), .fiq_o(fiq_o)
   );
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
   parameter int NUM_SRC = 128,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [NUM_SRC-1:0] en_q,
   input logic               ctrl_ge,
   input logic               ctrl_nse,
   input logic               irq_o,
   input logic               fiq_o
);
   localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'('h100);
   localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'('h180);

   a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_SET0) |=>
         ((en_q[DATA_W-1:0] & $past(reg_wdata)) == $past(reg_wdata)));

   a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_CLR0) |=> ((en_q[DATA_W-1:0] & $past(reg_wdata)) == '0));

   a_r8_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(ctrl_ge) && $past(ctrl_nse)));

   a_r8_fiq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> $past(ctrl_ge));

   a_r9_request_has_line: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o || fiq_o) |-> $past(|src_i));

   a_r1_no_early_request: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o || fiq_o) |-> $past(|en_q));
endmodule

bind secure_irq_ctrl sic_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .en_q(en_q), .ctrl_ge(ctrl_ge), .ctrl_nse(ctrl_nse),
   .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/secure_irq_ctrl_test.sv
module secure_irq_ctrl_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] src_i = '0;
   logic         reg_we = 1'b0;
   logic [11:0]  reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         irq_o, fiq_o;
   int           n_chk = 0;
   int           n_bad = 0;

   always #2 clk = ~clk;

   secure_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; src_i = '0; reg_we = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      src_i = '1;
      settle();
      rd(12'h000, d); check("R1 ctrl", d, 0);
      rd(12'h00C, d); check("R1 mask", d, 0);
      rd(12'h100, d); check("R1 enable", d, 0);
      rd(12'h08C, d); check("R1 security", d, 0);
      rd(12'h47C, d); check("R1 priority", d, 0);
      rd(12'hD0C, d); check("R1 pending", d, 0);
      check("R1 outputs", {30'b0, irq_o, fiq_o}, 0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      do_reset();
      wr(12'h100, 32'h0000_00F0);
      rd(12'h100, d); check("R2 set", d, 32'h0000_00F0);
      wr(12'h100, 32'h0000_000F);
      rd(12'h100, d); check("R2 zero bits keep", d, 32'h0000_00FF);
      wr(12'h180, 32'h0000_0030);
      rd(12'h100, d); check("R3 clear", d, 32'h0000_00CF);
      rd(12'h180, d); check("R2 read via clear word", d, 32'h0000_00CF);
      wr(12'h180, 32'h0);
      rd(12'h100, d); check("R3 zero bits keep", d, 32'h0000_00CF);
      wr(12'h10C, 32'h8000_0000);
      rd(12'h18C, d); check("R2 last bank", d, 32'h8000_0000);
      rd(12'h100, d); check("R2 other bank untouched", d, 32'h0000_00CF);
   endtask

   task automatic t_pending();
      logic [31:0] d;
      do_reset();
      wr(12'h100, 32'h0000_00CF);
      wr(12'h10C, 32'h8000_0000);
      src_i = '0;
      src_i[31:0] = 32'hF0F0_0F55;
      src_i[127] = 1'b1;
      src_i[126] = 1'b1;
      rd(12'hD00, d); check("R4 pending bank0", d, 32'h0000_0045);
      rd(12'hD0C, d); check("R4 pending bank3", d, 32'h8000_0000);
      src_i = '0;
      rd(12'hD00, d); check("R4 level no latch", d, 0);
   endtask

   task automatic t_prio();
      logic [31:0] d;
      do_reset();
      wr(12'h000, 32'h1);
      wr(12'h00C, 32'h20);
      wr(12'h10C, 32'h2000_0000);
      wr(12'h47C, 32'hFFFF_10FF);
      rd(12'h47C, d); check("R5 priority readback", d, 32'hFFFF_10FF);
      src_i[125] = 1'b1;
      settle();
      check("R5 byte lane 1 forwards", {31'b0, fiq_o}, 1);
      wr(12'h47C, 32'h0000_3000);
      settle();
      check("R5 byte lane 1 blocks", {31'b0, fiq_o}, 0);
   endtask

   task automatic t_mask();
      do_reset();
      wr(12'h000, 32'h1);
      wr(12'h100, 32'h20);
      wr(12'h404, 32'h0000_4000);
      src_i[5] = 1'b1;
      wr(12'h00C, 32'h40);
      settle();
      check("R6 equal mask blocks", {31'b0, fiq_o}, 0);
      wr(12'h00C, 32'h41);
      settle();
      check("R6 lower priority passes", {31'b0, fiq_o}, 1);
      wr(12'h404, 32'h0);
      wr(12'h00C, 32'h00);
      settle();
      check("R6 zero mask blocks all", {31'b0, fiq_o}, 0);
   endtask

   task automatic t_route();
      do_reset();
      wr(12'h100, 32'h20);
      wr(12'h00C, 32'h01);
      src_i[5] = 1'b1;
      wr(12'h000, 32'h3);
      wr(12'h080, 32'h20);
      settle();
      check("R7 nonsecure to irq", {30'b0, irq_o, fiq_o}, 32'h2);
      wr(12'h080, 32'h0);
      settle();
      check("R7 secure to fiq", {30'b0, irq_o, fiq_o}, 32'h1);
      wr(12'h000, 32'h1);
      settle();
      check("R8 fiq needs global only", {30'b0, irq_o, fiq_o}, 32'h1);
      wr(12'h080, 32'h20);
      settle();
      check("R8 irq needs nonsecure enable", {30'b0, irq_o, fiq_o}, 0);
      wr(12'h000, 32'h2);
      settle();
      check("R8 irq needs global", {30'b0, irq_o, fiq_o}, 0);
      wr(12'h080, 32'h0);
      settle();
      check("R8 fiq needs global", {30'b0, irq_o, fiq_o}, 0);
   endtask

   task automatic t_timing();
      do_reset();
      wr(12'h100, 32'h1);
      wr(12'h00C, 32'h01);
      wr(12'h080, 32'h1);
      wr(12'h000, 32'h3);
      src_i[0] = 1'b1;
      #1 check("R9 no change before edge", {31'b0, irq_o}, 0);
      settle();
      check("R9 rises after one edge", {31'b0, irq_o}, 1);
      src_i[0] = 1'b0;
      #1 check("R9 holds until edge", {31'b0, irq_o}, 1);
      settle();
      check("R9 falls after one edge", {31'b0, irq_o}, 0);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      t_reset();
      t_enable();
      t_pending();
      t_prio();
      t_mask();
      t_route();
      t_timing();
      summary();
   end
endmodule